// File: doc/BRIEF.md
# Opcode-Driven Request Frame Sequencer

This block runs one complete request to a power-management microcontroller over a byte-wide serial link. A lower-level byte shifter, outside this block, does the bit-level handshake. The caller loads up to 128 transmit bytes into a local buffer. It then pulses a start with an opcode, a transmit length and the free room in the receive buffer. The sequencer waits until the peer reports idle and sends the frame. It then clocks in the response and stores as much of it as fits. At the end it reports the stored byte count and an error flag.

The frame layout depends on the opcode. A constant lookup gives each opcode a signed send length and a signed receive length. A value of -1 means the count travels on the link as an explicit length byte. A non-negative value is a fixed count that both sides already know. A fixed send count that does not match the caller's length rejects the request before anything is sent.

Top module: `pwr_req_seq`

## Requirements
- R1: While rst_ni is low and right after it is released, busy_o, done_o, err_o and xfer_req_o are 0 and rx_count_o is 0.
- R2: By default, opcodes with bit 3 clear use send -1 and receive 0, and opcodes with bit 3 set use send -1 and receive -1. The default is overridden as follows (send,receive): 0x10 and 0x11 (1,0), 0x21 (0,0), 0x22 (2,0), 0x30 (4,0), 0x38 (0,4), 0x3B (2,1), 0x6B (0,8), 0x78 (0,-1), 0x7E (4,1), 0xD0 (0,0), 0xEA (0,1).
- R3: If the send entry is non-negative and tx_len_i differs from it, the request is rejected. No byte goes to the shifter, done_o rises on the cycle after start_i is sampled, err_o is 1 and rx_count_o is 0.
- R4: An accepted request asserts no xfer_req_o until peer_idle_i has been seen high. The opcode byte is the first byte offered after that.
- R5: The frame is sent in this order: the opcode byte, then tx_len_i as a length byte only when the send entry is -1, then the transmit buffer bytes from address 0 upward.
- R6: When the receive entry is -1, the first received byte gives the response length and is not stored. Otherwise the entry itself is the response length, and no length byte is received. A response length of 0 ends the request with no error.
- R7: If the response length exceeds the effective room, which is min(rx_room_i, 128), every response byte is still transferred. Only the first bytes up to the room are stored, at receive buffer addresses from 0 upward, and err_o is set.
- R8: done_o is a one-cycle pulse. At the pulse, rx_count_o holds the stored byte count. err_o holds its value until the next accepted start clears it.
- R9: start_i is ignored while busy_o is high. A request in flight completes unchanged.
- R10: A tx_len_i above 128 is rejected in the same way as R3, even for opcodes whose send entry is -1.
- R11: xfer_req_o is only high while busy_o is high. It stays high with xfer_byte_o stable until xfer_done_i. xfer_send_o is 1 for the bytes sent and 0 for the bytes received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a request when idle |
| opcode_i | input | 8 | Request opcode |
| tx_len_i | input | 8 | Number of transmit bytes |
| rx_room_i | input | 8 | Receive bytes the caller can accept |
| txb_we_i | input | 1 | Transmit buffer write enable |
| txb_addr_i | input | 7 | Transmit buffer write address |
| txb_data_i | input | 8 | Transmit buffer write data |
| rxb_addr_i | input | 7 | Receive buffer read address |
| rxb_data_o | output | 8 | Receive buffer read data (combinational) |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error of the last request |
| rx_count_o | output | 8 | Stored response byte count |
| peer_idle_i | input | 1 | Peer acknowledge line high (idle) |
| xfer_req_o | output | 1 | Byte transfer request to the shifter |
| xfer_send_o | output | 1 | 1 = send xfer_byte_o, 0 = receive |
| xfer_byte_o | output | 8 | Byte to send |
| xfer_done_i | input | 1 | Shifter completed the byte (one-cycle pulse) |
| xfer_rbyte_i | input | 8 | Received byte, valid with xfer_done_i |

## Verification
A rejected request raises done_o exactly one cycle after the edge that samples start_i, and the bench counts that latency. An accepted request first waits for peer_idle_i. Each xfer_done_i pulse moves the sequencer to the next byte on the following edge. done_o follows one cycle after the last transfer. The bench stands in for the byte shifter. It compares each offered byte, with its direction, against a queue built from the requirements at the moment it completes the transfer. It samples done_o, rx_count_o, err_o and the receive buffer on falling edges, and checks the cycle after the pulse for its fall.

// File: rtl/pwr_req_pkg.sv
`timescale 1ns/1ps
package pwr_req_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_OP, S_LEN, S_TXD, S_RXL, S_RXD, S_FIN
  } seq_state_e;

  typedef struct packed {
    logic signed [7:0] snd;
    logic signed [7:0] rcv;
  } len_pair_t;

  // -1 in a field: the count is carried on the link as a length byte
  function automatic len_pair_t lookup_len(input logic [7:0] op);
    len_pair_t p;
    p.snd = -8'sd1;
    p.rcv = op[3] ? -8'sd1 : 8'sd0;
    case (op)
      8'h10, 8'h11: begin p.snd = 8'sd1; p.rcv = 8'sd0;  end
      8'h21:        begin p.snd = 8'sd0; p.rcv = 8'sd0;  end
      8'h22:        begin p.snd = 8'sd2; p.rcv = 8'sd0;  end
      8'h30:        begin p.snd = 8'sd4; p.rcv = 8'sd0;  end
      8'h38:        begin p.snd = 8'sd0; p.rcv = 8'sd4;  end
      8'h3B:        begin p.snd = 8'sd2; p.rcv = 8'sd1;  end
      8'h6B:        begin p.snd = 8'sd0; p.rcv = 8'sd8;  end
      8'h78:        begin p.snd = 8'sd0; p.rcv = -8'sd1; end
      8'h7E:        begin p.snd = 8'sd4; p.rcv = 8'sd1;  end
      8'hD0:        begin p.snd = 8'sd0; p.rcv = 8'sd0;  end
      8'hEA:        begin p.snd = 8'sd0; p.rcv = 8'sd1;  end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pwr_len_rom.sv
`timescale 1ns/1ps
module pwr_len_rom
  import pwr_req_pkg::*;
(
  input  logic [7:0] op_i,
  output len_pair_t  pair_o
);
  assign pair_o = lookup_len(op_i);
endmodule

// File: rtl/pwr_byte_buf.sv
`timescale 1ns/1ps
module pwr_byte_buf #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pwr_req_seq.sv
`timescale 1ns/1ps
module pwr_req_seq
  import pwr_req_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    opcode_i,
  input  logic [7:0]    tx_len_i,
  input  logic [7:0]    rx_room_i,
  input  logic          txb_we_i,
  input  logic [AW-1:0] txb_addr_i,
  input  logic [7:0]    txb_data_i,
  input  logic [AW-1:0] rxb_addr_i,
  output logic [7:0]    rxb_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [CW-1:0] rx_count_o,
  input  logic          peer_idle_i,
  output logic          xfer_req_o,
  output logic          xfer_send_o,
  output logic [7:0]    xfer_byte_o,
  input  logic          xfer_done_i,
  input  logic [7:0]    xfer_rbyte_i
);
  localparam logic [7:0] DEPTH_B = 8'(DEPTH);

  seq_state_e state_q, rx_st;
  len_pair_t  pair_in, pair_q;
  logic [7:0] op_q, tx_len_q, room_q, idx_q, total_q;
  logic [CW-1:0] cnt_q;
  logic       err_q, bad_len, rx_we;
  logic [7:0] tx_rdata;

  pwr_len_rom u_rom (.op_i(opcode_i), .pair_o(pair_in));

  pwr_byte_buf #(.DEPTH(DEPTH)) u_txb (
    .clk_i(clk_i), .we_i(txb_we_i), .waddr_i(txb_addr_i), .wdata_i(txb_data_i),
    .raddr_i(idx_q[AW-1:0]), .rdata_o(tx_rdata)
  );

  assign rx_we = (state_q == S_RXD) && xfer_done_i && (idx_q < room_q);

  pwr_byte_buf #(.DEPTH(DEPTH)) u_rxb (
    .clk_i(clk_i), .we_i(rx_we), .waddr_i(idx_q[AW-1:0]), .wdata_i(xfer_rbyte_i),
    .raddr_i(rxb_addr_i), .rdata_o(rxb_data_o)
  );

  assign bad_len = (!pair_in.snd[7] && (tx_len_i != pair_in.snd[7:0]))
                || (tx_len_i > DEPTH_B);

  // first receive-phase state, chosen from the latched entry
  always_comb begin
    if (pair_q.rcv[7])              rx_st = S_RXL;
    else if (pair_q.rcv == 8'sd0)   rx_st = S_FIN;
    else                            rx_st = S_RXD;
  end

  always_comb begin
    xfer_req_o  = state_q inside {S_OP, S_LEN, S_TXD, S_RXL, S_RXD};
    xfer_send_o = state_q inside {S_OP, S_LEN, S_TXD};
    case (state_q)
      S_OP:    xfer_byte_o = op_q;
      S_LEN:   xfer_byte_o = tx_len_q;
      S_TXD:   xfer_byte_o = tx_rdata;
      default: xfer_byte_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      pair_q   <= '0;
      op_q     <= '0;
      tx_len_q <= '0;
      room_q   <= '0;
      idx_q    <= '0;
      total_q  <= '0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          op_q     <= opcode_i;
          tx_len_q <= tx_len_i;
          room_q   <= (rx_room_i > DEPTH_B) ? DEPTH_B : rx_room_i;
          pair_q   <= pair_in;
          cnt_q    <= '0;
          idx_q    <= '0;
          err_q    <= bad_len;
          state_q  <= bad_len ? S_FIN : S_WAIT;
        end
        S_WAIT: if (peer_idle_i) state_q <= S_OP;
        S_OP: if (xfer_done_i) begin
          if (pair_q.snd[7])          state_q <= S_LEN;
          else if (tx_len_q != 8'd0)  state_q <= S_TXD;
          else begin
            state_q <= rx_st;
            total_q <= pair_q.rcv[7:0];
          end
        end
        S_LEN: if (xfer_done_i) begin
          if (tx_len_q != 8'd0) state_q <= S_TXD;
          else begin
            state_q <= rx_st;
            total_q <= pair_q.rcv[7:0];
          end
        end
        S_TXD: if (xfer_done_i) begin
          if (idx_q == tx_len_q - 8'd1) begin
            idx_q   <= '0;
            state_q <= rx_st;
            total_q <= pair_q.rcv[7:0];
          end else begin
            idx_q <= idx_q + 8'd1;
          end
        end
        S_RXL: if (xfer_done_i) begin
          total_q <= xfer_rbyte_i;
          idx_q   <= '0;
          state_q <= (xfer_rbyte_i == 8'd0) ? S_FIN : S_RXD;
        end
        S_RXD: if (xfer_done_i) begin
          if (idx_q < room_q) cnt_q <= cnt_q + 1'b1;
          else                err_q <= 1'b1;
          if (idx_q == total_q - 8'd1) state_q <= S_FIN;
          else                         idx_q   <= idx_q + 8'd1;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_FIN);
  assign err_o      = err_q;
  assign rx_count_o = cnt_q;

endmodule

// File: rtl/pwr_req_seq_chk.sv
`timescale 1ns/1ps
module pwr_req_seq_chk #(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] rx_count_o,
  input logic          xfer_req_o,
  input logic          xfer_done_i,
  input logic [7:0]    xfer_byte_o
);
  // R11
  req_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> busy_o);

  // R11
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_done_i) |=> (xfer_req_o && $stable(xfer_byte_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  wait_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !xfer_req_o);

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  // R7
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rx_count_o <= CW'(DEPTH)));
endmodule

bind pwr_req_seq pwr_req_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .rx_count_o(rx_count_o), .xfer_req_o(xfer_req_o),
  .xfer_done_i(xfer_done_i), .xfer_byte_o(xfer_byte_o)
);

// File: tb/pwr_req_seq_bench.sv
`timescale 1ns/1ps
module pwr_req_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] opcode_i = '0, tx_len_i = '0, rx_room_i = '0;
  logic       txb_we_i = 1'b0;
  logic [6:0] txb_addr_i = '0, rxb_addr_i = '0;
  logic [7:0] txb_data_i = '0;
  logic [7:0] rxb_data_o;
  logic       busy_o, done_o, err_o;
  logic [7:0] rx_count_o;
  logic       peer_idle_i = 1'b1;
  logic       xfer_req_o, xfer_send_o;
  logic [7:0] xfer_byte_o;
  logic       xfer_done_i = 1'b0;
  logic [7:0] xfer_rbyte_i = '0;

  pwr_req_seq u_pwr_req_seq (.*);

  always #2.5 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int exp_tx_q[$];
  int sh_rsp_q[$];
  int tx_data_q[$];
  int rsp_data_q[$];
  int tx_seen = 0, rx_xfers = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // table from R2
  task automatic ref_len(input int op, output int snd, output int rcv);
    snd = -1;
    rcv = ((op & 8) != 0) ? -1 : 0;
    case (op)
      'h10, 'h11: begin snd = 1; rcv = 0; end
      'h21: begin snd = 0; rcv = 0; end
      'h22: begin snd = 2; rcv = 0; end
      'h30: begin snd = 4; rcv = 0; end
      'h38: begin snd = 0; rcv = 4; end
      'h3B: begin snd = 2; rcv = 1; end
      'h6B: begin snd = 0; rcv = 8; end
      'h78: begin snd = 0; rcv = -1; end
      'h7E: begin snd = 4; rcv = 1; end
      'hD0: begin snd = 0; rcv = 0; end
      'hEA: begin snd = 0; rcv = 1; end
      default: ;
    endcase
  endtask

  // byte shifter stand-in, checks each offered byte (R5, R11)
  initial begin
    forever begin
      @(negedge clk_i);
      xfer_done_i = 1'b0;
      if (xfer_req_o) begin
        repeat (2) @(negedge clk_i);
        if (xfer_send_o) begin
          tx_seen++;
          if (exp_tx_q.size() == 0) chk("R5", "unexpected send byte", xfer_byte_o, -1);
          else chk("R5", "sent byte", xfer_byte_o, exp_tx_q.pop_front());
        end else begin
          rx_xfers++;
          chk("R11", "receive while bytes still due", exp_tx_q.size(), 0);
          xfer_rbyte_i = (sh_rsp_q.size() != 0) ? 8'(sh_rsp_q.pop_front()) : 8'hEE;
        end
        xfer_done_i = 1'b1;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && xfer_req_o && !busy_o) begin
      n_tests++; n_fail++;
      $display("FAIL R11 req outside busy: actual 1 expected 0");
    end
  end

  task automatic run_req(input string tag, input int op, input int txlen, input int room,
                         input int idle_delay, input bit poke);
    int snd, rcv, total, stored, xfers, cyc, off;
    bit reject, e_err;
    ref_len(op, snd, rcv);
    for (int i = 0; i < tx_data_q.size() && i < 128; i++) begin
      @(negedge clk_i);
      txb_we_i = 1'b1; txb_addr_i = 7'(i); txb_data_i = 8'(tx_data_q[i]);
    end
    @(negedge clk_i);
    txb_we_i = 1'b0;
    reject = (snd >= 0 && txlen != snd) || txlen > 128;
    exp_tx_q.delete();
    if (!reject) begin
      exp_tx_q.push_back(op);
      if (snd < 0) exp_tx_q.push_back(txlen);
      for (int i = 0; i < txlen; i++) exp_tx_q.push_back(tx_data_q[i]);
    end
    sh_rsp_q = rsp_data_q;
    off = (rcv < 0) ? 1 : 0;
    total = (rcv < 0) ? rsp_data_q[0] : rcv;
    stored = reject ? 0 : ((total < room) ? total : room);
    e_err = reject || (total > room);
    xfers = reject ? 0 : off + total;
    tx_seen = 0; rx_xfers = 0;
    if (idle_delay > 0) peer_idle_i = 1'b0;
    opcode_i = 8'(op); tx_len_i = 8'(txlen); rx_room_i = 8'(room);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 1;
    fork
      begin
        while (!done_o && cyc < 4000) begin
          @(negedge clk_i);
          cyc++;
        end
      end
      begin
        if (idle_delay > 0) begin
          for (int k = 0; k < idle_delay; k++) begin
            chk("R4", "req before peer idle", xfer_req_o, 0);
            @(negedge clk_i);
          end
          peer_idle_i = 1'b1;
        end
      end
      begin
        if (poke) begin
          repeat (3) @(negedge clk_i);
          opcode_i = 8'hD0; tx_len_i = 8'd0; start_i = 1'b1;
          @(negedge clk_i);
          start_i = 1'b0;
        end
      end
    join
    chk(tag, "done seen", done_o, 1);
    if (reject) chk(tag, "reject latency", cyc, 1);
    chk(tag, "rx count", rx_count_o, stored);
    chk(tag, "err", err_o, e_err);
    chk(tag, "bytes left unsent", exp_tx_q.size(), 0);
    chk(tag, "send transfers", tx_seen, reject ? 0 : 1 + (snd < 0 ? 1 : 0) + txlen);
    chk(tag, "receive transfers", rx_xfers, xfers);
    for (int i = 0; i < stored; i++) begin
      rxb_addr_i = 7'(i);
      #0.5;
      chk(tag, "rx buffer byte", rxb_data_o, rsp_data_q[i + off]);
    end
    @(negedge clk_i);
    chk("R8", "done one cycle", done_o, 0);
    chk("R8", "idle after done", busy_o, 0);
    chk("R8", "err holds after done", err_o, e_err);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "busy in reset", busy_o, 0);
    chk("R1", "done in reset", done_o, 0);
    chk("R1", "err in reset", err_o, 0);
    chk("R1", "count in reset", rx_count_o, 0);
    chk("R1", "req in reset", xfer_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "busy after reset", busy_o, 0);

    // R6 fixed 4-byte response, R4 waits for peer idle
    tx_data_q.delete(); rsp_data_q.delete();
    rsp_data_q.push_back('h11); rsp_data_q.push_back('h22);
    rsp_data_q.push_back('h33); rsp_data_q.push_back('h44);
    run_req("R6", 'h38, 0, 8, 5, 0);

    // R2 fixed zero-length response
    tx_data_q.delete(); rsp_data_q.delete();
    run_req("R2", 'hD0, 0, 8, 0, 0);

    // R2 fixed one-byte send
    tx_data_q.delete(); rsp_data_q.delete();
    tx_data_q.push_back('h5A);
    run_req("R2", 'h10, 1, 8, 0, 0);

    // R3 send length mismatch
    tx_data_q.delete(); rsp_data_q.delete();
    tx_data_q.push_back(1); tx_data_q.push_back(2);
    run_req("R3", 'h10, 2, 8, 0, 0);

    // R5 length byte frame, R9 start while busy ignored
    tx_data_q.delete(); rsp_data_q.delete();
    tx_data_q.push_back('hA1); tx_data_q.push_back('hB2); tx_data_q.push_back('hC3);
    run_req("R9", 'h01, 3, 8, 0, 1);

    // R7 overflow: 5 bytes into room 3
    tx_data_q.delete(); rsp_data_q.delete();
    rsp_data_q.push_back(5);
    for (int i = 1; i <= 5; i++) rsp_data_q.push_back(i * 16 + i);
    run_req("R7", 'h78, 0, 3, 0, 0);
    repeat (3) @(negedge clk_i);
    chk("R8", "err sticky while idle", err_o, 1);

    // R6 length byte both ways; R8 err cleared by new start
    tx_data_q.delete(); rsp_data_q.delete();
    tx_data_q.push_back('h07); tx_data_q.push_back('h08);
    rsp_data_q.push_back(2); rsp_data_q.push_back('h66); rsp_data_q.push_back('h77);
    run_req("R6", 'h09, 2, 10, 0, 0);

    // R10 oversize transmit length
    tx_data_q.delete(); rsp_data_q.delete();
    run_req("R10", 'h01, 200, 8, 0, 0);

    // R7 fixed response with zero room
    tx_data_q.delete(); rsp_data_q.delete();
    tx_data_q.push_back(1); tx_data_q.push_back(2);
    rsp_data_q.push_back('h99);
    run_req("R7", 'h3B, 2, 0, 0, 0);

    // R6 length byte of zero
    tx_data_q.delete(); rsp_data_q.delete();
    rsp_data_q.push_back(0);
    run_req("R6", 'h78, 0, 8, 0, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule